// File: doc/BRIEF.md
# Auto-masking prioritized interrupt controller

This block gathers level-sensitive, active-high interrupt lines from peripheral blocks into a single request line to a processor. Each source's hardware line is combined by OR with a software trigger bit. A source is active when that combined condition is high and its mask bit is clear. When any source is active, the request line is high. Among the active sources, the one with the lowest number always wins.

Software takes interrupts by reading a dedicated event port. The read returns a word that names the winning source. The same access also sets that source's mask bit, so it serves as the acknowledge and no end-of-interrupt write is needed. When the handler has finished, software clears the mask bit again. Mask and trigger bits are changed through write-one-to-set and write-one-to-clear word registers, with 32 sources per word. The same registers can be read back to see the current bit state.

Top module: `irqc_top`

## Requirements
- R1: After reset every mask bit is set, every trigger bit is clear, `irqOut` is low and `evtData` is zero.
- R2: An unmasked source whose hardware line is high drives `irqOut` high in the same cycle. `irqOut` falls in the same cycle the line drops, provided no other source is active.
- R3: A source whose mask bit is set never raises `irqOut` and is never returned by an event read.
- R4: A set trigger bit makes its source pending even when the hardware line is low. Clearing the trigger bit removes that pending condition.
- R5: When several sources are active, an event read returns the lowest-numbered one.
- R6: An event read that returns a source sets that source's mask bit. A following read therefore returns the next-priority active source.
- R7: An event read with no active source returns zero and leaves every mask bit unchanged.
- R8: The event word is returned in `evtData` one cycle after `evtRd`. It carries type code 1 (hardware interrupt) in bits [17:16] and the source number in bits [9:0]. All other bits are zero. Type code 0 means no event.
- R9: `regAddr` is {group, word}. The group field occupies the top two bits: 0 = mask set, 1 = mask clear, 2 = trigger set, 3 = trigger clear. Bit b of word w controls source 32*w+b. Bits written as zero have no effect.
- R10: A register read returns its result in `regRdata` one cycle after `regRe`. Groups 0 and 1 return the addressed mask word, and groups 2 and 3 return the addressed trigger word.
- R11: If an event read and a mask-clear write to the delivered source fall in the same cycle, the mask bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwIrq | input | NUM_SRC | Level-sensitive hardware interrupt lines |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | WIDX_W+2 | {group, word index} |
| regWdata | input | 32 | Write data (one bit per source) |
| regRdata | output | 32 | Read data, one cycle after regRe |
| evtRd | input | 1 | Event read / acknowledge strobe |
| evtData | output | 32 | Event word, one cycle after evtRd |
| irqOut | output | 1 | Request line: any unmasked pending source |

## Verification
A mask or trigger bit held in the wrong state shows up on `irqOut` in the same cycle. It also appears as a wrong word in the next event read, and as a wrong word in a read-back one cycle after `regRe`. A priority fault shows up as the wrong source number in the first event read that follows several sources becoming active at once. A missing auto-mask shows up as the same source being returned twice in a row. An acknowledge that loses to a same-cycle clear write shows up in a mask read-back right after it. The bench drives each of these situations and compares every event and read word against a queue of values it predicts itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int EVT_TYPE_LSB = 16;
  localparam int EVT_SRC_W    = 10;
  localparam int REG_W        = 32;

  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_HW   = 2'd1,
    EVT_FAST = 2'd2
  } irqc_evt_type_e;

  typedef enum logic [1:0] {
    GRP_MASK_SET = 2'd0,
    GRP_MASK_CLR = 2'd1,
    GRP_TRIG_SET = 2'd2,
    GRP_TRIG_CLR = 2'd3
  } irqc_grp_e;

  // Strobes from control to datapath, one per action
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic trigSet;
    logic trigClr;
    logic rdMask;
    logic rdTrig;
    logic rdNull;
    logic evtAck;
  } irqc_strobe_t;

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irqc_ctl.sv
module irqc_ctl
  import irqc_pkg::*;
#(
  parameter int NW     = 2,
  parameter int WIDX_W = 1
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [WIDX_W+1:0] regAddr,
  input  logic              evtRd,
  output irqc_strobe_t      strobe,
  output logic [WIDX_W-1:0] wordIdx
);

  irqc_grp_e grp;
  logic      inRange;

  always_comb begin
    grp     = irqc_grp_e'(regAddr[WIDX_W+1:WIDX_W]);
    wordIdx = regAddr[WIDX_W-1:0];
    inRange = (32'(wordIdx) < 32'(NW));
  end

  always_comb begin
    strobe         = '0;
    strobe.maskSet = regWe && inRange && (grp == GRP_MASK_SET);
    strobe.maskClr = regWe && inRange && (grp == GRP_MASK_CLR);
    strobe.trigSet = regWe && inRange && (grp == GRP_TRIG_SET);
    strobe.trigClr = regWe && inRange && (grp == GRP_TRIG_CLR);
    strobe.rdMask  = regRe && inRange && (grp == GRP_MASK_SET || grp == GRP_MASK_CLR);
    strobe.rdTrig  = regRe && inRange && (grp == GRP_TRIG_SET || grp == GRP_TRIG_CLR);
    strobe.rdNull  = regRe && !inRange;
    strobe.evtAck  = evtRd;
  end

endmodule

// File: rtl/irqc_dp.sv
module irqc_dp
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NW      = 2,
  parameter int WIDX_W  = 1,
  parameter int SRC_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  irqc_strobe_t       strobe,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   regRdata,
  output logic [REG_W-1:0]   evtData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] activeVec
);

  localparam int PAD_W = NW * REG_W;

  logic [NUM_SRC-1:0] maskQ, maskNext;
  logic [NUM_SRC-1:0] trigQ, trigNext;
  logic [NUM_SRC-1:0] pendVec;
  logic [PAD_W-1:0]   maskPad, trigPad, wrVec;
  logic               winValid;
  logic [SRC_W-1:0]   winIdx;
  logic [REG_W-1:0]   evtWord;

  assign pendVec   = hwIrq | trigQ;
  assign activeVec = pendVec & ~maskQ;
  assign irqOut    = |activeVec;
  assign maskVec   = maskQ;

  irqc_prio #(.N(NUM_SRC), .IDX_W(SRC_W)) u_prio (
    .req   (activeVec),
    .valid (winValid),
    .idx   (winIdx)
  );

  // Word-aligned views; unused high bits read as masked / untriggered
  generate
    if (PAD_W > NUM_SRC) begin : g_pad
      assign maskPad = {{(PAD_W - NUM_SRC){1'b1}}, maskQ};
      assign trigPad = {{(PAD_W - NUM_SRC){1'b0}}, trigQ};
    end else begin : g_nopad
      assign maskPad = maskQ;
      assign trigPad = trigQ;
    end
  endgenerate

  always_comb begin
    wrVec = '0;
    for (int w = 0; w < NW; w++) begin
      if (32'(wordIdx) == 32'(w)) wrVec[w*REG_W +: REG_W] = wrData;
    end
  end

  // Ack is applied last so it wins over a same-cycle clear (R11)
  always_comb begin
    maskNext = maskQ;
    trigNext = trigQ;
    if (strobe.maskSet) maskNext = maskNext | wrVec[NUM_SRC-1:0];
    if (strobe.maskClr) maskNext = maskNext & ~wrVec[NUM_SRC-1:0];
    if (strobe.trigSet) trigNext = trigNext | wrVec[NUM_SRC-1:0];
    if (strobe.trigClr) trigNext = trigNext & ~wrVec[NUM_SRC-1:0];
    if (strobe.evtAck && winValid) maskNext[winIdx] = 1'b1;
  end

  always_comb begin
    evtWord = '0;
    if (winValid) begin
      evtWord[EVT_TYPE_LSB +: 2] = EVT_HW;
      evtWord[EVT_SRC_W-1:0]     = EVT_SRC_W'(winIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= '1;
      trigQ    <= '0;
      evtData  <= '0;
      regRdata <= '0;
    end else begin
      maskQ <= maskNext;
      trigQ <= trigNext;
      if (strobe.evtAck) evtData <= evtWord;
      if (strobe.rdMask)      regRdata <= maskPad[32'(wordIdx)*REG_W +: REG_W];
      else if (strobe.rdTrig) regRdata <= trigPad[32'(wordIdx)*REG_W +: REG_W];
      else if (strobe.rdNull) regRdata <= '0;
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter  int NUM_SRC = 64,
  localparam int NW      = (NUM_SRC + 31) / 32,
  localparam int WIDX_W  = (NW > 1) ? $clog2(NW) : 1,
  localparam int ADDR_W  = WIDX_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               evtRd,
  output logic [31:0]        evtData,
  output logic               irqOut
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  irqc_strobe_t       strobe;
  logic [WIDX_W-1:0]  wordIdx;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] activeVec;

  irqc_ctl #(.NW(NW), .WIDX_W(WIDX_W)) u_ctl (
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .evtRd   (evtRd),
    .strobe  (strobe),
    .wordIdx (wordIdx)
  );

  irqc_dp #(.NUM_SRC(NUM_SRC), .NW(NW), .WIDX_W(WIDX_W), .SRC_W(SRC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hwIrq     (hwIrq),
    .strobe    (strobe),
    .wordIdx   (wordIdx),
    .wrData    (regWdata),
    .regRdata  (regRdata),
    .evtData   (evtData),
    .irqOut    (irqOut),
    .maskVec   (maskVec),
    .activeVec (activeVec)
  );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic               evtRd,
  input logic [31:0]        evtData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] activeVec
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               ackPrev;
  logic [NUM_SRC-1:0] activePrev;
  logic               belowClear;
  logic [SRC_W-1:0]   evtIdx;

  assign evtIdx = evtData[SRC_W-1:0];

  always_ff @(posedge clk) begin
    ackPrev    <= rstN && evtRd && irqOut;
    activePrev <= activeVec;
  end

  always_comb begin
    belowClear = 1'b1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i < int'(evtIdx) && activePrev[i]) belowClear = 1'b0;
    end
  end

  assert_quiet_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtRd && !irqOut) |=> (evtData == 32'd0));

  assert_quiet_no_mask_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtRd && !irqOut && !regWe) |=> $stable(maskVec));

  assert_ack_masks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtRd && irqOut) |=> maskVec[evtIdx]);

  assert_word_format_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtData != 32'd0) |-> (evtData[17:16] == 2'd1 && evtData[31:18] == '0 &&
                            evtData[15:10] == '0 && int'(evtData[9:0]) < NUM_SRC));

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackPrev |-> (belowClear && activePrev[evtIdx]));

  assert_all_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |-> !irqOut);

endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .evtRd     (evtRd),
  .evtData   (evtData),
  .irqOut    (irqOut),
  .maskVec   (maskVec),
  .activeVec (activeVec)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

  localparam int N      = 64;
  localparam int WIDX   = 1;
  localparam int ADDR_W = WIDX + 2;
  localparam int CLK_NS = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [N-1:0]      hwIrq = '0;
  logic              regWe = 1'b0;
  logic              regRe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              evtRd = 1'b0;
  logic [31:0]       evtData;
  logic              irqOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] evtExpQ[$];
  string       evtTagQ[$];
  logic [31:0] regExpQ[$];
  string       regTagQ[$];

  always #(CLK_NS / 2) clk = ~clk;

  irqc_top #(.NUM_SRC(N)) u_irqc_top (
    .clk      (clk),
    .rstN     (rstN),
    .hwIrq    (hwIrq),
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .evtRd    (evtRd),
    .evtData  (evtData),
    .irqOut   (irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hwEvt(input int src);
    return 32'h0001_0000 | 32'(src);
  endfunction

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic regWrite(input int grp, input int w, input logic [31:0] d);
    regWe    = 1'b1;
    regAddr  = ADDR_W'((grp << WIDX) | w);
    regWdata = d;
    cycle();
    regWe    = 1'b0;
    regWdata = '0;
  endtask

  task automatic regRead(input int grp, input int w, input logic [31:0] exp, input string tag);
    regRe   = 1'b1;
    regAddr = ADDR_W'((grp << WIDX) | w);
    regExpQ.push_back(exp);
    regTagQ.push_back(tag);
    cycle();
    regRe = 1'b0;
  endtask

  task automatic evtRead(input logic [31:0] exp, input string tag);
    evtRd = 1'b1;
    evtExpQ.push_back(exp);
    evtTagQ.push_back(tag);
    cycle();
    evtRd = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    check(irqOut === exp, tag, 32'(irqOut), 32'(exp));
  endtask

  // Monitors: the result appears one edge after the strobe
  initial forever begin
    @(posedge clk);
    if (evtRd) begin
      @(negedge clk);
      if (evtExpQ.size() == 0) check(1'b0, "R8 unexpected event", evtData, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = evtExpQ.pop_front();
        t = evtTagQ.pop_front();
        check(evtData === e, t, evtData, e);
      end
    end
  end

  initial forever begin
    @(posedge clk);
    if (regRe) begin
      @(negedge clk);
      if (regExpQ.size() == 0) check(1'b0, "R10 unexpected read", regRdata, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = regExpQ.pop_front();
        t = regTagQ.pop_front();
        check(regRdata === e, t, regRdata, e);
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cycle();
    rstN = 1'b1;
    cycle();

    // R1 reset state
    checkIrq(1'b0, "R1 irqOut after reset");
    check(evtData === 32'd0, "R1 evtData after reset", evtData, 32'd0);
    regRead(0, 0, 32'hFFFF_FFFF, "R1 mask word0 reset");
    regRead(1, 1, 32'hFFFF_FFFF, "R1 mask word1 reset");
    regRead(3, 1, 32'h0, "R1 trig word1 reset");
    evtRead(32'd0, "R1 R7 empty event after reset");

    // R3 masked source stays silent
    hwIrq[5] = 1'b1;
    cycle();
    checkIrq(1'b0, "R3 masked source no irq");
    evtRead(32'd0, "R3 masked source not reported");

    // R2 unmask -> irq, R6 R8 read acks and masks
    regWrite(1, 0, 32'h20);
    checkIrq(1'b1, "R2 unmasked level raises irq");
    evtRead(hwEvt(5), "R6 R8 event for source 5");
    checkIrq(1'b0, "R6 irq drops after auto-mask");
    regRead(0, 0, 32'hFFFF_FFFF, "R6 mask bit 5 set by read");

    // R2 level drop, R7 empty read has no side effect
    regWrite(1, 0, 32'h20);
    hwIrq[5] = 1'b0;
    cycle();
    checkIrq(1'b0, "R2 irq follows line low");
    evtRead(32'd0, "R7 empty read returns zero");
    regRead(0, 0, 32'hFFFF_FFDF, "R7 empty read leaves masks");

    // R5 R6 priority and sequential delivery
    regWrite(1, 0, 32'hFFFF_FFFF);
    regWrite(1, 1, 32'hFFFF_FFFF);
    hwIrq[40] = 1'b1;
    hwIrq[3]  = 1'b1;
    hwIrq[63] = 1'b1;
    cycle();
    evtRead(hwEvt(3),  "R5 lowest source first");
    evtRead(hwEvt(40), "R6 next source after auto-mask");
    evtRead(hwEvt(63), "R5 last source");
    evtRead(32'd0,     "R6 all delivered sources masked");
    regRead(1, 1, 32'h8000_0100, "R9 mask word1 after acks");
    hwIrq = '0;

    // R4 software trigger
    regWrite(1, 0, 32'hFFFF_FFFF);
    regWrite(1, 1, 32'hFFFF_FFFF);
    checkIrq(1'b0, "R4 idle before trigger");
    regWrite(2, 1, 32'h2);
    checkIrq(1'b1, "R4 trigger raises irq");
    regRead(2, 1, 32'h2, "R10 trig word1 readback");
    evtRead(hwEvt(33), "R4 triggered source 33");
    regWrite(1, 1, 32'h2);
    evtRead(hwEvt(33), "R4 trigger still pending after unmask");
    regWrite(3, 1, 32'h2);
    regWrite(1, 1, 32'h2);
    checkIrq(1'b0, "R4 trigger cleared");
    regRead(3, 1, 32'h0, "R4 trig word1 cleared");

    // R9 zero write has no effect
    regWrite(0, 0, 32'h0);
    regRead(0, 0, 32'h0, "R9 zero write leaves mask word0");
    regWrite(0, 1, 32'h0000_0001);
    regRead(1, 1, 32'h0000_0001, "R9 set bit0 of word1 is source 32");
    regWrite(1, 1, 32'h0000_0001);

    // R11 ack wins over same-cycle clear
    hwIrq[7] = 1'b1;
    cycle();
    regWe    = 1'b1;
    regAddr  = ADDR_W'((1 << WIDX) | 0);
    regWdata = 32'h80;
    evtRd    = 1'b1;
    evtExpQ.push_back(hwEvt(7));
    evtTagQ.push_back("R11 event for source 7");
    cycle();
    regWe = 1'b0;
    evtRd = 1'b0;
    regRead(0, 0, 32'h80, "R11 mask stays set");
    checkIrq(1'b0, "R11 irq low after ack");
    hwIrq = '0;

    repeat (3) cycle();
    check(evtExpQ.size() == 0 && regExpQ.size() == 0, "R8 R10 scoreboard drained",
          32'(evtExpQ.size() + regExpQ.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule